// File: doc/BRIEF.md
# Deferred Floating-Point Trap Controller

This block keeps the IEEE exception bookkeeping for a floating-point unit whose instructions may run either sequentially or pipelined. Each cycle it accepts up to `NPORT` completion reports. A report carries the exception flags the instruction raised, whether it ran pipelined, whether it was modeless, and its PC. The block holds three five-bit registers: sticky exception-occurred flags, trap-enable modes, and deferred-trap flags. All three use the bit order invalid (bit 0), divide-by-zero (bit 1), overflow (bit 2), underflow (bit 3) and inexact (bit 4).

A sequential, mode-observing instruction that raises an enabled exception produces a precise trap request carrying its PC. A pipelined instruction that does the same takes no trap. The enabled flags are added to the deferred-trap register instead.

A synchronize-branch request settles the deferred record. The branch is taken when nothing is deferred. It falls through to re-execution code when something is deferred. When it is a null sync with no recovery code, it escalates to a non-IEEE system trap. The sync request and the mode/status access port both act only in a cycle where the floating-point unit reports idle, so the requester holds its request until the acknowledge arrives.

Top module: `fp_trap_ctrl`

## Requirements
- R1: After reset, all three registers read zero, and `trap_req`, `sync_done` and `csr_ack` are low.
- R2: Every valid report ORs its flags into the sticky exception register. This holds whatever its mode, and it happens in the cycle of the report. A flag stays set until a CSR write to select 1 replaces the register.
- R3: A valid report that is neither pipelined nor modeless and has `flags & enable` nonzero raises `trap_req` one cycle later. The trap carries that report's PC and `trap_cause = flags & enable`, where enable is the value held before that cycle. When several such reports arrive together, the lowest port index wins.
- R4: A pipelined, mode-observing report never raises `trap_req`. Its `flags & enable` is ORed into the deferred register.
- R5: A modeless report never raises `trap_req` and never changes the deferred register. It still records exception flags as in R2.
- R6: A sync that fires raises `sync_done` one cycle later, with exactly one outcome set. The outcome is `sync_taken` if the deferred value is zero, `sync_fall` if it is nonzero and `sync_null` is low, and `sync_systrap` if it is nonzero and `sync_null` is high.
- R7: A firing sync leaves the deferred register at zero.
- R8: `sync_req` and `csr_req` act only in a cycle with `fpu_idle` high. In any other cycle they change no state and produce no `sync_done` or `csr_ack`.
- R9: A sync judges the deferred value after that same cycle's reports and CSR write have been merged in.
- R10: A CSR access that fires raises `csr_ack` one cycle later. `csr_rdata` then holds the selected register's value from before the access: select 0 is enable, 1 is exceptions, 2 is deferred, and 3 reads zero. A write replaces the selected register, and same-cycle report flags are ORed on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | NPORT | Completion report valid, one bit per port |
| rpt_flags | input | 5*NPORT | Exception flags per port |
| rpt_pipe | input | NPORT | Report came from a pipelined instruction |
| rpt_modeless | input | NPORT | Report came from a modeless instruction |
| rpt_pc | input | PCW*NPORT | PC per port |
| fpu_idle | input | 1 | All floating-point units are idle |
| sync_req | input | 1 | Synchronize-branch request |
| sync_null | input | 1 | Sync has no recovery code |
| csr_req | input | 1 | Mode/status access request |
| csr_we | input | 1 | Access is a write |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | 5 | Write data |
| trap_req | output | 1 | Precise trap request pulse |
| trap_pc | output | PCW | PC of the trapping instruction |
| trap_cause | output | 5 | Enabled exceptions that caused the trap |
| sync_done | output | 1 | Sync resolved |
| sync_taken | output | 1 | Branch taken |
| sync_fall | output | 1 | Fall through to re-execution |
| sync_systrap | output | 1 | Unrecovered pipelined trap |
| csr_ack | output | 1 | CSR access done |
| csr_rdata | output | 5 | CSR read data |

## Verification
Several properties are checked on every cycle by the assertions. A resolved sync carries exactly one outcome, and it only follows an idle cycle. A trap request always has a nonzero cause. The deferred register is zero after a sync and stays put when no pipelined hit arrives. Exception flags never drop without a write. Other behaviours are shown only by the bench scenarios, which compare against a separate model: choosing the lowest port, timing the enable against a same-cycle write, merging same-cycle reports before the sync decision, and the value a CSR read returns.

// File: rtl/fptrap_pkg.sv
package fptrap_pkg;
  localparam int NEXC = 5;
  typedef logic [NEXC-1:0] exc_t;
  localparam logic [1:0] SEL_EN  = 2'd0;
  localparam logic [1:0] SEL_EXC = 2'd1;
  localparam logic [1:0] SEL_DEF = 2'd2;

  // Enabled portion of a flag set
  function automatic exc_t enabled_hits(exc_t flags, exc_t en);
    return flags & en;
  endfunction

  // Next value of a sticky register with optional replace-write
  function automatic exc_t sticky_next(exc_t cur, logic wr, exc_t wdata, exc_t add);
    return (wr ? wdata : cur) | add;
  endfunction
endpackage

// File: rtl/fptrap_merge.sv
module fptrap_merge
  import fptrap_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int PCW   = 16
) (
  input  logic [NPORT-1:0]      rpt_valid,
  input  logic [NPORT*NEXC-1:0] rpt_flags,
  input  logic [NPORT-1:0]      rpt_pipe,
  input  logic [NPORT-1:0]      rpt_modeless,
  input  logic [NPORT*PCW-1:0]  rpt_pc,
  input  exc_t                  en,
  output exc_t                  all_flags,
  output exc_t                  pipe_hits,
  output logic                  seq_hit,
  output logic [PCW-1:0]        seq_pc,
  output exc_t                  seq_cause
);
  exc_t [NPORT-1:0] flg;
  logic [NPORT-1:0] seq_port_hit;
  exc_t [NPORT-1:0] pipe_port;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign flg[p] = rpt_valid[p] ? rpt_flags[p*NEXC +: NEXC] : '0;
    assign seq_port_hit[p] = !rpt_pipe[p] && !rpt_modeless[p] &&
                             (enabled_hits(flg[p], en) != '0);
    assign pipe_port[p] = (rpt_pipe[p] && !rpt_modeless[p]) ?
                          enabled_hits(flg[p], en) : '0;
  end

  always_comb begin
    all_flags = '0;
    pipe_hits = '0;
    seq_pc    = '0;
    seq_cause = '0;
    for (int p = 0; p < NPORT; p++) begin
      all_flags = all_flags | flg[p];
      pipe_hits = pipe_hits | pipe_port[p];
    end
    // descending scan so the lowest index wins
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (seq_port_hit[p]) begin
        seq_pc    = rpt_pc[p*PCW +: PCW];
        seq_cause = enabled_hits(flg[p], en);
      end
    end
  end

  assign seq_hit = |seq_port_hit;
endmodule

// File: rtl/fptrap_sync.sv
module fptrap_sync
  import fptrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic is_null,
  input  exc_t def_seen,
  output logic done,
  output logic taken,
  output logic fall,
  output logic systrap
);
  logic pending;
  assign pending = (def_seen != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; taken <= 1'b0; fall <= 1'b0; systrap <= 1'b0;
    end else begin
      done    <= fire;
      taken   <= fire && !pending;
      fall    <= fire && pending && !is_null;
      systrap <= fire && pending && is_null;
    end
  end

  AST_SYNC_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({taken, fall, systrap}) == 1)); // R6
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(taken || fall || systrap)); // R6
endmodule

// File: rtl/fp_trap_ctrl.sv
module fp_trap_ctrl
  import fptrap_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int PCW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      rpt_valid,
  input  logic [NPORT*5-1:0]    rpt_flags,
  input  logic [NPORT-1:0]      rpt_pipe,
  input  logic [NPORT-1:0]      rpt_modeless,
  input  logic [NPORT*PCW-1:0]  rpt_pc,
  input  logic                  fpu_idle,
  input  logic                  sync_req,
  input  logic                  sync_null,
  input  logic                  csr_req,
  input  logic                  csr_we,
  input  logic [1:0]            csr_sel,
  input  logic [4:0]            csr_wdata,
  output logic                  trap_req,
  output logic [PCW-1:0]        trap_pc,
  output logic [4:0]            trap_cause,
  output logic                  sync_done,
  output logic                  sync_taken,
  output logic                  sync_fall,
  output logic                  sync_systrap,
  output logic                  csr_ack,
  output logic [4:0]            csr_rdata
);
  exc_t exc_q, en_q, def_q;
  exc_t all_flags, pipe_hits, seq_cause, def_after, rd_sel;
  logic seq_hit;
  logic [PCW-1:0] seq_pc;

  // named events
  logic sync_fire, csr_fire, wr_en, wr_exc, wr_def;
  assign sync_fire = sync_req && fpu_idle;
  assign csr_fire  = csr_req && fpu_idle;
  assign wr_en     = csr_fire && csr_we && (csr_sel == SEL_EN);
  assign wr_exc    = csr_fire && csr_we && (csr_sel == SEL_EXC);
  assign wr_def    = csr_fire && csr_we && (csr_sel == SEL_DEF);

  fptrap_merge #(.NPORT(NPORT), .PCW(PCW)) i_merge (
    .rpt_valid(rpt_valid), .rpt_flags(rpt_flags), .rpt_pipe(rpt_pipe),
    .rpt_modeless(rpt_modeless), .rpt_pc(rpt_pc), .en(en_q),
    .all_flags(all_flags), .pipe_hits(pipe_hits), .seq_hit(seq_hit),
    .seq_pc(seq_pc), .seq_cause(seq_cause)
  );

  assign def_after = sticky_next(def_q, wr_def, csr_wdata, pipe_hits);

  always_comb begin
    case (csr_sel)
      SEL_EN:  rd_sel = en_q;
      SEL_EXC: rd_sel = exc_q;
      SEL_DEF: rd_sel = def_q;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q <= '0; en_q <= '0; def_q <= '0;
      trap_req <= 1'b0; trap_pc <= '0; trap_cause <= '0;
      csr_ack <= 1'b0; csr_rdata <= '0;
    end else begin
      exc_q <= sticky_next(exc_q, wr_exc, csr_wdata, all_flags);
      en_q  <= wr_en ? csr_wdata : en_q;
      def_q <= sync_fire ? '0 : def_after;
      trap_req <= seq_hit;
      if (seq_hit) begin
        trap_pc    <= seq_pc;
        trap_cause <= seq_cause;
      end
      csr_ack <= csr_fire;
      if (csr_fire) csr_rdata <= rd_sel;
    end
  end

  fptrap_sync i_sync (
    .clk(clk), .rst_n(rst_n), .fire(sync_fire), .is_null(sync_null),
    .def_seen(def_after), .done(sync_done), .taken(sync_taken),
    .fall(sync_fall), .systrap(sync_systrap)
  );

  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause != '0)); // R3
  AST_SYNC_CLEARS_DEF: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |=> (def_q == '0)); // R7
  AST_DEF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_hits == '0 && !sync_fire && !wr_def) |=> $stable(def_q)); // R5
  AST_EXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_exc |=> ((exc_q & $past(exc_q)) == $past(exc_q))); // R2
  AST_SYNC_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> $past(fpu_idle)); // R8
  AST_ACK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_ack |-> $past(fpu_idle)); // R8
endmodule

// File: tb/test_fp_trap_ctrl.sv
module test_fp_trap_ctrl;
  localparam int NPORT = 2;
  localparam int PCW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORT-1:0] rpt_valid = '0, rpt_pipe = '0, rpt_modeless = '0;
  logic [NPORT*5-1:0] rpt_flags = '0;
  logic [NPORT*PCW-1:0] rpt_pc = '0;
  logic fpu_idle = 1'b1, sync_req = 1'b0, sync_null = 1'b0;
  logic csr_req = 1'b0, csr_we = 1'b0;
  logic [1:0] csr_sel = '0;
  logic [4:0] csr_wdata = '0;
  logic trap_req, sync_done, sync_taken, sync_fall, sync_systrap, csr_ack;
  logic [PCW-1:0] trap_pc;
  logic [4:0] trap_cause, csr_rdata;

  always #2.5 clk = ~clk;

  fp_trap_ctrl #(.NPORT(NPORT), .PCW(PCW)) i_fp_trap_ctrl (.*);

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // next-cycle stimulus
  logic [4:0] d_flags [NPORT];
  logic [PCW-1:0] d_pc [NPORT];
  logic [NPORT-1:0] d_valid, d_pipe, d_ml;
  logic d_idle, d_sync, d_null, d_csr, d_we;
  logic [1:0] d_sel;
  logic [4:0] d_wdata;

  // model
  logic [4:0] m_exc, m_en, m_def;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] m_read(logic [1:0] s);
    case (s)
      2'd0: return m_en;
      2'd1: return m_exc;
      2'd2: return m_def;
      default: return 5'd0;
    endcase
  endfunction

  task automatic step();
    logic e_trap, e_done, e_tk, e_fl, e_sy, e_ack, any_rep, all_ml, all_pipe;
    logic [4:0] e_cause, e_rd, pipe_add, all_add, def_seen;
    logic [PCW-1:0] e_pc;
    @(negedge clk);
    rpt_valid = d_valid; rpt_pipe = d_pipe; rpt_modeless = d_ml;
    for (int p = 0; p < NPORT; p++) begin
      rpt_flags[p*5 +: 5] = d_flags[p];
      rpt_pc[p*PCW +: PCW] = d_pc[p];
    end
    fpu_idle = d_idle; sync_req = d_sync; sync_null = d_null;
    csr_req = d_csr; csr_we = d_we; csr_sel = d_sel; csr_wdata = d_wdata;
    // expected
    e_trap = 0; e_cause = 0; e_pc = 0; pipe_add = 0; all_add = 0;
    any_rep = 0; all_ml = 1; all_pipe = 1;
    for (int p = 0; p < NPORT; p++) begin
      if (d_valid[p]) begin
        any_rep = 1;
        all_add |= d_flags[p];
        if (!d_ml[p]) all_ml = 0;
        if (!d_pipe[p] || d_ml[p]) all_pipe = 0;
        if (!d_ml[p] && d_pipe[p]) pipe_add |= d_flags[p] & m_en;
        if (!d_ml[p] && !d_pipe[p] && !e_trap && (d_flags[p] & m_en) != 0) begin
          e_trap = 1; e_cause = d_flags[p] & m_en; e_pc = d_pc[p];
        end
      end
    end
    e_ack = d_csr && d_idle;
    e_rd = m_read(d_sel);
    def_seen = ((e_ack && d_we && d_sel == 2) ? d_wdata : m_def) | pipe_add;
    e_done = d_sync && d_idle;
    e_tk = e_done && def_seen == 0;
    e_fl = e_done && def_seen != 0 && !d_null;
    e_sy = e_done && def_seen != 0 && d_null;
    m_exc = ((e_ack && d_we && d_sel == 1) ? d_wdata : m_exc) | all_add;
    if (e_ack && d_we && d_sel == 0) m_en = d_wdata;
    m_def = e_done ? 5'd0 : def_seen;
    @(posedge clk); #1;
    chk(trap_req == e_trap, "R3 trap_req", trap_req, e_trap);
    if (e_trap) begin
      chk(trap_pc == e_pc, "R3 trap_pc", trap_pc, e_pc);
      chk(trap_cause == e_cause, "R3 trap_cause", trap_cause, e_cause);
    end
    if (any_rep && all_ml) chk(!trap_req, "R5 modeless no trap", trap_req, 0);
    if (any_rep && all_pipe) chk(!trap_req, "R4 pipelined no trap", trap_req, 0);
    if (d_sync && !d_idle) chk(!sync_done, "R8 sync waits idle", sync_done, 0);
    if (d_csr && !d_idle) chk(!csr_ack, "R8 csr waits idle", csr_ack, 0);
    chk(sync_done == e_done, "R6 sync_done", sync_done, e_done);
    if (e_done)
      chk({sync_taken, sync_fall, sync_systrap} == {e_tk, e_fl, e_sy},
          any_rep ? "R9 sync outcome with same-cycle reports" : "R6 sync outcome",
          {sync_taken, sync_fall, sync_systrap}, {e_tk, e_fl, e_sy});
    chk(csr_ack == e_ack, "R10 csr_ack", csr_ack, e_ack);
    if (e_ack)
      chk(csr_rdata == e_rd, d_sel == 2 ? "R7 R4 deferred read" :
          d_sel == 1 ? "R2 R5 exception read" : "R10 csr read", csr_rdata, e_rd);
  endtask

  task automatic idle_in();
    d_valid = 0; d_pipe = 0; d_ml = 0; d_idle = 1; d_sync = 0; d_null = 0;
    d_csr = 0; d_we = 0; d_sel = 0; d_wdata = 0;
    for (int p = 0; p < NPORT; p++) begin d_flags[p] = 0; d_pc[p] = 0; end
  endtask

  task automatic rd(logic [1:0] s);
    idle_in(); d_csr = 1; d_sel = s; step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_exc = 0; m_en = 0; m_def = 0;
    idle_in();
    repeat (3) @(posedge clk);
    #1;
    chk(!trap_req && !sync_done && !csr_ack, "R1 reset outputs", {trap_req, sync_done, csr_ack}, 0);
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s));
      chk(csr_rdata == 0, "R1 reset register", csr_rdata, 0);
    end
    // enable all traps
    idle_in(); d_csr = 1; d_we = 1; d_sel = 0; d_wdata = 5'h1f; step();
    // pipelined overflow (bit 2) then null sync -> system trap
    idle_in(); d_valid = 1; d_pipe = 1; d_flags[0] = 5'b00100; step();
    rd(2); chk(csr_rdata == 5'b00100, "R4 deferred overflow", csr_rdata, 5'b00100);
    idle_in(); d_sync = 1; d_null = 1; step();
    chk(sync_systrap, "R6 null sync escalates", sync_systrap, 1);
    rd(2); chk(csr_rdata == 0, "R7 deferred cleared", csr_rdata, 0);
    idle_in(); d_sync = 1; step();
    chk(sync_taken, "R6 empty sync taken", sync_taken, 1);
    // pipelined report in the same cycle as a sync
    idle_in(); d_valid = 1; d_pipe = 1; d_flags[0] = 5'b00001; d_sync = 1; step();
    chk(sync_fall, "R9 same-cycle deferral falls through", sync_fall, 1);
    // two sequential traps: port 0 wins
    idle_in(); d_valid = 2'b11; d_flags[0] = 5'b10000; d_flags[1] = 5'b00001;
    d_pc[0] = 16'h1234; d_pc[1] = 16'h5678; step();
    chk(trap_pc == 16'h1234, "R3 lowest port wins", trap_pc, 16'h1234);
    // modeless report: recorded but no trap
    idle_in(); d_valid = 1; d_ml = 1; d_flags[0] = 5'b01000; step();
    rd(1); chk(csr_rdata[3], "R5 modeless still recorded", csr_rdata, 5'b01000);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      idle_in();
      for (int p = 0; p < NPORT; p++) begin
        d_valid[p] = $urandom_range(0, 1);
        d_pipe[p]  = $urandom_range(0, 1);
        d_ml[p]    = ($urandom_range(0, 3) == 0);
        d_flags[p] = 5'($urandom & $urandom & $urandom);
        d_pc[p]    = 16'($urandom);
      end
      d_idle = ($urandom_range(0, 3) != 0);
      d_sync = ($urandom_range(0, 7) == 0);
      d_null = $urandom_range(0, 1);
      d_csr  = ($urandom_range(0, 3) == 0);
      d_we   = ($urandom_range(0, 3) == 0);
      d_sel  = 2'($urandom);
      d_wdata = 5'($urandom);
      step();
    end
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule